// File: doc/BRIEF.md
# PID duty cycle calculator with dither

This block works out the duty cycle command for a switching regulator once per switching period. A period strobe starts each update. At that edge the block takes a signed quantized error code and an unsigned reference word, and the reference word acts as a feedforward term. It adds proportional, derivative and integral contributions to that reference in two's complement arithmetic. The result is a fine command. The block clamps it to the range from zero to full scale. All quantities are in duty units normalized to the input voltage.

The downstream modulator is coarser than the fine command by DITH_W bits. The block therefore drops those low bits and rounds the remaining coarse value up on a rotating share of periods. Over eight periods the coarse outputs then average to the fine value. A pair of saturation flags from the converter can force the output fully off or fully on for one period. The registered coarse command leaves the block with a one-cycle valid pulse, one clock after the strobe.

Top module: `duty_pid_dither`

## Requirements
- R1: After reset, duty_o is 0 and valid_o is 0. The integrator, the stored previous error and the dither counter all start at 0.
- R2: Each clock in which tick_i is high performs exactly one update. valid_o is high in the following clock only. duty_o keeps its value in every clock that follows a clock without tick_i.
- R3: The unclamped sum is ref_i + kp_i*e + kd_i*(e - e_prev) + floor(ki_i*I / 2^I_SHIFT). Here e is err_i (signed), e_prev is the error stored at the previous update, I is the integrator before this update, the gains are unsigned, and I_SHIFT = 4. The fine command is this sum clamped to 0..1023.
- R4: On each update, unless R5 or R8 holds it, the integrator becomes I + e, clamped to 0..1023.
- R5: When the unclamped sum of R3 is below 0 or above 1023, the integrator keeps its value for that update.
- R6: The output is floor(fine/8) + 1 when (fine mod 8) is greater than the dither counter c, and floor(fine/8) otherwise. The result is capped at 127. The counter c is used and then advances by one modulo 8 on every update.
- R7: With a constant fine command of at most 1016, any eight consecutive outputs add up to the fine command.
- R8: When sat_lo_i is high at the update, the output is 0. Otherwise, when sat_hi_i is high, the output is 127. During such an override the integrator holds, while the previous error and the dither counter still update.
- R9: The error sampled at each update, overridden or not, becomes e_prev for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Switching period strobe, one clock wide |
| err_i | input | 6 | Quantized error code, two's complement |
| ref_i | input | 10 | Reference word in fine duty units |
| kp_i | input | 6 | Proportional gain, unsigned |
| ki_i | input | 6 | Integral gain, unsigned, scaled by 2^-4 |
| kd_i | input | 6 | Derivative gain, unsigned |
| sat_lo_i | input | 1 | Force output off for this period |
| sat_hi_i | input | 1 | Force output fully on for this period |
| duty_o | output | 7 | Coarse duty command for the modulator |
| valid_o | output | 1 | One-clock pulse marking a new duty_o |

## Verification
A wrong integrator value does not appear at the ports until an update with a nonzero integral gain, so the bench runs integral ramps. In these the error in the state shows up in the very next output and grows from then on. A wrong stored previous error corrupts only the update right after it, which is why derivative steps are checked individually. A misaligned dither counter shows up in the rounding choice of the current period, and a wrong rate or pattern breaks the eight-period sum. A missed integrator hold during a clamp or an override appears as a wrong value in the first unclamped output that follows.

// File: rtl/pidd_pkg.sv
package pidd_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_LOW  = 2'd1,
    OVR_HIGH = 2'd2
  } ovr_e;

  // forcing off takes priority over forcing on
  function automatic ovr_e pick_override(input logic lo, input logic hi);
    if (lo)      return OVR_LOW;
    else if (hi) return OVR_HIGH;
    else         return OVR_NONE;
  endfunction

endpackage

// File: rtl/pidd_state.sv
module pidd_state #(
  parameter int DUTY_W = 10,
  parameter int ERR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     hold,
  input  logic signed [ERR_W-1:0]  err,
  output logic [DUTY_W-1:0]        integ_q,
  output logic signed [ERR_W-1:0]  err_prev_q
);
  localparam int X_W = DUTY_W + 2;

  function automatic logic [DUTY_W-1:0] accumulate(
    input logic [DUTY_W-1:0] cur, input logic signed [ERR_W-1:0] e);
    logic signed [X_W-1:0] acc;
    logic signed [X_W-1:0] top;
    acc = $signed({2'b00, cur}) + $signed({{(X_W-ERR_W){e[ERR_W-1]}}, e});
    top = $signed({2'b00, {DUTY_W{1'b1}}});
    if (acc[X_W-1])     return '0;
    else if (acc > top) return '1;
    else                return acc[DUTY_W-1:0];
  endfunction

  logic [DUTY_W-1:0] integ_next;
  assign integ_next = accumulate(integ_q, err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q    <= '0;
      err_prev_q <= '0;
    end else if (tick) begin
      err_prev_q <= err;
      if (!hold) integ_q <= integ_next;
    end
  end
endmodule

// File: rtl/pidd_terms.sv
module pidd_terms #(
  parameter int DUTY_W  = 10,
  parameter int ERR_W   = 6,
  parameter int GAIN_W  = 6,
  parameter int I_SHIFT = 4,
  parameter int SUM_W   = DUTY_W + GAIN_W + ERR_W + 2
) (
  input  logic signed [ERR_W-1:0] err,
  input  logic signed [ERR_W-1:0] err_prev,
  input  logic [DUTY_W-1:0]       integ,
  input  logic [DUTY_W-1:0]       ref_w,
  input  logic [GAIN_W-1:0]       kp,
  input  logic [GAIN_W-1:0]       ki,
  input  logic [GAIN_W-1:0]       kd,
  output logic [DUTY_W-1:0]       fine,
  output logic                    out_of_range
);
  function automatic logic signed [SUM_W-1:0] sx(input logic signed [ERR_W-1:0] v);
    return $signed({{(SUM_W-ERR_W){v[ERR_W-1]}}, v});
  endfunction

  function automatic logic signed [SUM_W-1:0] zg(input logic [GAIN_W-1:0] v);
    return $signed({{(SUM_W-GAIN_W){1'b0}}, v});
  endfunction

  function automatic logic signed [SUM_W-1:0] zd(input logic [DUTY_W-1:0] v);
    return $signed({{(SUM_W-DUTY_W){1'b0}}, v});
  endfunction

  logic signed [SUM_W-1:0] p_term, d_term, i_term, raw;
  logic signed [SUM_W-1:0] full_s;

  assign full_s = zd({DUTY_W{1'b1}});
  assign p_term = zg(kp) * sx(err);
  assign d_term = zg(kd) * (sx(err) - sx(err_prev));
  assign i_term = (zg(ki) * zd(integ)) >>> I_SHIFT;
  assign raw    = zd(ref_w) + p_term + d_term + i_term;

  always_comb begin
    out_of_range = 1'b0;
    fine         = raw[DUTY_W-1:0];
    if (raw[SUM_W-1]) begin
      out_of_range = 1'b1;
      fine         = '0;
    end else if (raw > full_s) begin
      out_of_range = 1'b1;
      fine         = '1;
    end
  end
endmodule

// File: rtl/pidd_dither.sv
module pidd_dither
  import pidd_pkg::*;
#(
  parameter int DUTY_W = 10,
  parameter int DITH_W = 3,
  parameter int HW_W   = DUTY_W - DITH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DUTY_W-1:0] fine,
  input  ovr_e              ovr,
  output logic [HW_W-1:0]   duty_q,
  output logic              valid_q,
  output logic [DITH_W-1:0] cnt_q
);
  function automatic logic [HW_W-1:0] round_share(
    input logic [DUTY_W-1:0] f, input logic [DITH_W-1:0] c);
    logic [HW_W-1:0] coarse;
    coarse = f[DUTY_W-1:DITH_W];
    if ((f[DITH_W-1:0] > c) && (coarse != {HW_W{1'b1}}))
      return coarse + 1'b1;
    else
      return coarse;
  endfunction

  logic [HW_W-1:0] next_duty;

  always_comb begin
    case (ovr)
      OVR_LOW:  next_duty = '0;
      OVR_HIGH: next_duty = '1;
      default:  next_duty = round_share(fine, cnt_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= tick;
      if (tick) begin
        duty_q <= next_duty;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/duty_pid_dither.sv
module duty_pid_dither
  import pidd_pkg::*;
#(
  parameter int DUTY_W  = 10,
  parameter int DITH_W  = 3,
  parameter int ERR_W   = 6,
  parameter int GAIN_W  = 6,
  parameter int I_SHIFT = 4,
  localparam int HW_W   = DUTY_W - DITH_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [DUTY_W-1:0]       ref_i,
  input  logic [GAIN_W-1:0]       kp_i,
  input  logic [GAIN_W-1:0]       ki_i,
  input  logic [GAIN_W-1:0]       kd_i,
  input  logic                    sat_lo_i,
  input  logic                    sat_hi_i,
  output logic [HW_W-1:0]         duty_o,
  output logic                    valid_o
);
  logic [DUTY_W-1:0]       integ_q;
  logic signed [ERR_W-1:0] err_prev_q;
  logic [DUTY_W-1:0]       fine;
  logic                    out_of_range;
  logic                    integ_hold;
  logic [DITH_W-1:0]       dith_cnt;
  ovr_e                    ovr;

  assign ovr        = pick_override(sat_lo_i, sat_hi_i);
  assign integ_hold = out_of_range || (ovr != OVR_NONE);

  pidd_state #(.DUTY_W(DUTY_W), .ERR_W(ERR_W)) state_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .hold(integ_hold),
    .err(err_i), .integ_q(integ_q), .err_prev_q(err_prev_q)
  );

  pidd_terms #(.DUTY_W(DUTY_W), .ERR_W(ERR_W), .GAIN_W(GAIN_W),
               .I_SHIFT(I_SHIFT)) terms_i (
    .err(err_i), .err_prev(err_prev_q), .integ(integ_q), .ref_w(ref_i),
    .kp(kp_i), .ki(ki_i), .kd(kd_i), .fine(fine), .out_of_range(out_of_range)
  );

  pidd_dither #(.DUTY_W(DUTY_W), .DITH_W(DITH_W)) dither_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .fine(fine), .ovr(ovr),
    .duty_q(duty_o), .valid_q(valid_o), .cnt_q(dith_cnt)
  );
endmodule

// File: rtl/pidd_checker.sv
module pidd_checker #(
  parameter int DUTY_W = 10,
  parameter int DITH_W = 3,
  parameter int HW_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              sat_lo_i,
  input logic              sat_hi_i,
  input logic [HW_W-1:0]   duty_o,
  input logic              valid_o,
  input logic              integ_hold,
  input logic [DUTY_W-1:0] integ_q,
  input logic [DITH_W-1:0] dith_cnt
);
  a_r2_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> valid_o);

  a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !valid_o);

  a_r2_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(duty_o));

  a_r8_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && sat_lo_i) |=> (duty_o == '0));

  a_r8_force_on: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && sat_hi_i && !sat_lo_i) |=> (duty_o == {HW_W{1'b1}}));

  a_r5_integ_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && integ_hold) |=> $stable(integ_q));

  a_r6_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (dith_cnt == DITH_W'($past(dith_cnt) + 1'b1)));

  a_r6_counter_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(dith_cnt));
endmodule

bind duty_pid_dither pidd_checker #(.DUTY_W(DUTY_W), .DITH_W(DITH_W), .HW_W(HW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sat_lo_i(sat_lo_i),
  .sat_hi_i(sat_hi_i), .duty_o(duty_o), .valid_o(valid_o),
  .integ_hold(integ_hold), .integ_q(integ_q), .dith_cnt(dith_cnt)
);

// File: tb/duty_pid_dither_tb_top.sv
`timescale 1ns/1ps
module duty_pid_dither_tb_top;
  localparam int FULL = 1023;
  localparam int HWMAX = 127;
  localparam int ISH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic signed [5:0] err = '0;
  logic [9:0] refw = '0;
  logic [5:0] kp = '0, ki = '0, kd = '0;
  logic slo = 1'b0, shi = 1'b0;
  logic [6:0] duty;
  logic valid;

  always #2.5 clk = ~clk;

  duty_pid_dither dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .err_i(err), .ref_i(refw),
    .kp_i(kp), .ki_i(ki), .kd_i(kd), .sat_lo_i(slo), .sat_hi_i(shi),
    .duty_o(duty), .valid_o(valid)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  int m_integ = 0, m_prev = 0, m_cnt = 0;
  int last_duty = 0;
  bit acc_on = 0;
  int acc_sum = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: model computes expected output, then one strobe is issued
  task automatic period(input int e, input int r, input int p, input int i,
                        input int d, input bit lo, input bit hi, input string tag);
    int raw, f, outv;
    raw = r + p*e + d*(e - m_prev) + ((i*m_integ) >> ISH);
    if (lo || hi) begin
      outv = lo ? 0 : HWMAX;
    end else begin
      f = (raw < 0) ? 0 : (raw > FULL) ? FULL : raw;
      if (raw >= 0 && raw <= FULL) begin
        m_integ = m_integ + e;
        if (m_integ < 0) m_integ = 0;
        if (m_integ > FULL) m_integ = FULL;
      end
      outv = (f >> 3) + (((f & 7) > m_cnt) ? 1 : 0);
      if (outv > HWMAX) outv = HWMAX;
    end
    m_cnt = (m_cnt + 1) % 8;
    m_prev = e;
    exp_q.push_back(outv);
    tag_q.push_back(tag);
    @(negedge clk);
    err = e[5:0]; refw = r[9:0]; kp = p[5:0]; ki = i[5:0]; kd = d[5:0];
    slo = lo; shi = hi; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected valid", int'(duty), -1);
        end else begin
          int ev;
          string tg;
          ev = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(int'(duty) == ev, tg, int'(duty), ev);
        end
        last_duty = int'(duty);
        if (acc_on) acc_sum += int'(duty);
      end else begin
        check(int'(duty) == last_duty, "R2 duty held between strobes", int'(duty), last_duty);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(duty == 0, "R1 reset duty", int'(duty), 0);
    check(valid == 0, "R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero state means ref alone reaches output with integral gain on
    period(0, 400, 0, 16, 0, 0, 0, "R1 zero integrator and prev error");
    // R3 proportional and feedforward
    period(5, 400, 2, 0, 0, 0, 0, "R3 proportional plus reference");
    period(-7, 600, 3, 0, 0, 0, 0, "R3 negative error");
    // R9 / R3 derivative steps
    period(10, 300, 0, 0, 4, 0, 0, "R9 derivative uses stored error");
    period(10, 300, 0, 0, 4, 0, 0, "R9 derivative zero on equal error");
    period(-12, 500, 0, 0, 5, 0, 0, "R9 derivative negative step");
    // R4 integrator ramp with ki=16 (term equals integrator)
    for (int k = 0; k < 6; k++) period(20, 100, 0, 16, 0, 0, 0, "R4 integrator ramp");
    period(-30, 200, 0, 24, 0, 0, 0, "R4 integrator decrease");
    period(3, 200, 0, 9, 0, 0, 0, "R3 integral floor scaling");
    // R5 clamp low and high hold the integrator
    period(-31, 10, 40, 16, 0, 0, 0, "R5 clamp low output");
    period(0, 100, 0, 16, 0, 0, 0, "R5 integrator held after low clamp");
    period(31, 1000, 40, 16, 0, 0, 0, "R5 clamp high output");
    period(0, 100, 0, 16, 0, 0, 0, "R5 integrator held after high clamp");
    // R8 overrides
    period(25, 900, 5, 16, 0, 1, 0, "R8 force off");
    period(25, 10, 5, 16, 0, 0, 1, "R8 force on");
    period(25, 500, 5, 16, 0, 1, 1, "R8 off has priority");
    period(0, 100, 0, 16, 3, 0, 0, "R8 integrator held, prev error kept");
    // R6 dither pattern at a fine value with odd low bits
    for (int k = 0; k < 8; k++) period(0, 515, 0, 0, 0, 0, 0, "R6 dither share");
    // R7 eight-period average
    acc_sum = 0; acc_on = 1;
    for (int k = 0; k < 8; k++) period(0, 733, 0, 0, 0, 0, 0, "R7 average window");
    acc_on = 0;
    check(acc_sum == 733, "R7 eight outputs sum to fine", acc_sum, 733);
    // R6 cap at top of range
    for (int k = 0; k < 8; k++) period(0, 1023, 0, 0, 0, 0, 0, "R6 cap at full scale");
    period(0, 7, 0, 0, 0, 0, 0, "R6 low code rounding");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 every strobe answered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule